// File: doc/BRIEF.md
# NAND Copy-Back Command Sequencer

This block is the host-side engine that moves one page inside an asynchronous 8-bit NAND flash device without passing the page data through the host. A client hands it a source row address and a target row address over a valid/ready request port. The block then drives the flash bus through two phases. The first phase loads the source page into the device's internal page buffer. The second phase programs that buffer into the target page. It waits on the ready/busy line after each phase. At the end it reads the device status byte and reports the outcome on a one-cycle done pulse.

Before it touches the bus, the block checks the address pair. The device can copy a page only into a page that has the same plane parity. Larger devices also require the same die-select bit. A pair that breaks either rule is refused at once, and no bus cycle is issued for it. A watchdog on each busy wait turns a device that never goes busy, or never comes back, into a timeout report, so the block cannot hang.

Each command or address byte is latched by a write-enable low pulse of programmable length, followed by a programmable high time. The status byte is read with a read-enable pulse that uses the same timing.

Top module: `nand_copy_seq`

## Requirements
- R1: `reqReady` is 1 only while the block is idle, and `flashCeN` is high whenever `reqReady` is 1. A legal request accepted on `reqValid && reqReady` drops `reqReady` and drives `flashCeN` low in the next cycle. `reqReady` returns to 1 two cycles after the done pulse at the latest.
- R2: Phase one writes, in this order: command 0x00, two column address bytes of 0x00, the three source row bytes with the least significant byte first, then command 0x35. Command bytes carry `flashCle`=1 and `flashAle`=0. Address bytes carry `flashCle`=0 and `flashAle`=1.
- R3: After command 0x35, the block waits until the ready input has gone low and then high again before it writes command 0x85.
- R4: Phase two writes command 0x85, two column bytes of 0x00, the three target row bytes with the least significant byte first, then command 0x10. The `flashCle`/`flashAle` marking is the same as in R2.
- R5: After the busy period that follows 0x10, the block writes command 0x70 and reads one byte with a `flashReN` low pulse. Only bit 0 of that byte is used: 0 reports status code 0 (pass) and 1 reports status code 1 (fail).
- R6: A request whose rows differ in row bit `PLANE_BIT` (default 6) is refused with status code 2 (illegal). Its done pulse comes in the cycle after acceptance, `flashCeN` stays high, and no write-enable pulse occurs.
- R7: With `CHECK_DIE` at 1 (the default), a request whose rows differ in row bit `DIE_BIT` (default 18) is refused in the same way as in R6, with status code 2. With `CHECK_DIE` at 0, that bit is not compared.
- R8: Every `flashWeN` low pulse lasts exactly `LOW_CLKS` clocks. `flashDataOut` and `flashCle` hold steady while `flashWeN` is low.
- R9: If the ready input fails to go low, or fails to return high, within about `TIMEOUT` clocks of a wait, the block ends the operation with status code 3 (timeout). It issues no further bus cycles and releases `flashCeN`.
- R10: `doneValid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block idle and able to accept a request |
| srcRow | input | 24 | Source page row address |
| dstRow | input | 24 | Target page row address |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 0 pass, 1 fail, 2 illegal pair, 3 timeout; valid with doneValid |
| flashCeN | output | 1 | Chip enable, active low |
| flashCle | output | 1 | Command latch enable |
| flashAle | output | 1 | Address latch enable |
| flashWeN | output | 1 | Write enable, active low |
| flashReN | output | 1 | Read enable, active low |
| flashDataOut | output | 8 | Byte driven onto the flash I/O bus |
| flashDataIn | input | 8 | Byte read from the flash I/O bus |
| flashDataOe | output | 1 | Output enable for flashDataOut |
| flashReady | input | 1 | Ready/busy from the device, high when ready |

## Verification
The assertions assume that the ready input stays high from the end of one busy period until the next command that starts a busy period. They also assume that `flashDataIn` is only meaningful while `flashReN` is low. The bench's device model follows both rules: it pulls ready low only a few clocks after a 0x35 or 0x10 write and releases it by itself. It drives a filler value on the data input whenever read enable is high. The request rows are held steady while `reqValid` is asserted, because the pair check looks at them in the cycle of acceptance.

// File: rtl/nand_copy_pkg.sv
package nand_copy_pkg;

  localparam int COL_CYCLES = 2;
  localparam int ROW_CYCLES = 3;
  localparam int ROW_W      = 8 * ROW_CYCLES;
  localparam int RIDX_W     = $clog2(ROW_CYCLES);

  // Step numbering of the byte schedule
  localparam int STEP_RD_CONF_I   = 1 + COL_CYCLES + ROW_CYCLES;
  localparam int STEP_PROG_I      = STEP_RD_CONF_I + 1;
  localparam int STEP_PROG_CONF_I = STEP_PROG_I + 1 + COL_CYCLES + ROW_CYCLES;
  localparam int STEP_STATUS_I    = STEP_PROG_CONF_I + 1;
  localparam int STEP_W           = $clog2(STEP_STATUS_I + 1);

  localparam logic [STEP_W-1:0] STEP_RD_CONF   = STEP_W'(STEP_RD_CONF_I);
  localparam logic [STEP_W-1:0] STEP_PROG      = STEP_W'(STEP_PROG_I);
  localparam logic [STEP_W-1:0] STEP_PROG_CONF = STEP_W'(STEP_PROG_CONF_I);
  localparam logic [STEP_W-1:0] STEP_STATUS    = STEP_W'(STEP_STATUS_I);

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_READ_GO = 8'h35;
  localparam logic [7:0] OP_COPY    = 8'h85;
  localparam logic [7:0] OP_COPY_GO = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  typedef enum logic [1:0] {
    RES_PASS    = 2'd0,
    RES_FAIL    = 2'd1,
    RES_ILLEGAL = 2'd2,
    RES_TIMEOUT = 2'd3
  } result_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_LO, S_WR_HI, S_WAIT_BUSY, S_WAIT_READY, S_RD_LO, S_RD_HI, S_DONE
  } state_e;

  typedef struct packed {
    logic accept;
    logic loadLow;
    logic loadHigh;
    logic nextStep;
    logic clearWatch;
    logic tickWatch;
    logic captureStatus;
    logic markIllegal;
    logic markTimeout;
  } strobe_t;

endpackage

// File: rtl/nand_copy_dp.sv
module nand_copy_dp
  import nand_copy_pkg::*;
#(
  parameter int PLANE_BIT = 6,
  parameter int DIE_BIT   = 18,
  parameter bit CHECK_DIE = 1'b1,
  parameter int LOW_CLKS  = 3,
  parameter int HIGH_CLKS = 2,
  parameter int TIMEOUT   = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [ROW_W-1:0] srcRow,
  input  logic [ROW_W-1:0] dstRow,
  input  logic [7:0]       dataIn,
  input  logic             readyIn,
  output logic [7:0]       outByte,
  output logic             byteIsCmd,
  output logic             busyAfter,
  output logic             readAfter,
  output logic             timerDone,
  output logic             watchExpired,
  output logic             readyQ,
  output logic             illegalPair,
  output result_e          result
);

  localparam int MAXP = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
  localparam int TW   = $clog2(MAXP + 1);
  localparam int WW   = $clog2(TIMEOUT + 1);

  logic [ROW_W-1:0]  srcQ, dstQ;
  logic [STEP_W-1:0] step;
  logic [TW-1:0]     timerQ;
  logic [WW-1:0]     watchQ;
  logic              readyMeta;
  logic              planeMismatch, dieMismatch;
  logic [STEP_W-1:0] srcRel, dstRel;
  logic              unusedStatusBits;

  assign unusedStatusBits = ^dataIn[7:1];

  // Address pair legality
  assign planeMismatch = srcRow[PLANE_BIT] != dstRow[PLANE_BIT];
  generate
    if (CHECK_DIE) begin : g_dieCheck
      assign dieMismatch = srcRow[DIE_BIT] != dstRow[DIE_BIT];
    end else begin : g_noDieCheck
      assign dieMismatch = 1'b0;
    end
  endgenerate
  assign illegalPair = planeMismatch || dieMismatch;

  // Request latch and byte schedule pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
      step <= '0;
    end else if (strobe.accept) begin
      srcQ <= srcRow;
      dstQ <= dstRow;
      step <= '0;
    end else if (strobe.nextStep && step != STEP_STATUS) begin
      step <= step + 1'b1;
    end
  end

  assign srcRel = step - STEP_W'(1 + COL_CYCLES);
  assign dstRel = step - STEP_W'(STEP_PROG_I + 1 + COL_CYCLES);

  always_comb begin
    outByte   = OP_STATUS;
    byteIsCmd = 1'b1;
    if (step == '0) begin
      outByte = OP_READ;
    end else if (step < STEP_W'(1 + COL_CYCLES)) begin
      outByte   = 8'h00;
      byteIsCmd = 1'b0;
    end else if (step < STEP_RD_CONF) begin
      outByte   = srcQ[8*srcRel[RIDX_W-1:0] +: 8];
      byteIsCmd = 1'b0;
    end else if (step == STEP_RD_CONF) begin
      outByte = OP_READ_GO;
    end else if (step == STEP_PROG) begin
      outByte = OP_COPY;
    end else if (step < STEP_W'(STEP_PROG_I + 1 + COL_CYCLES)) begin
      outByte   = 8'h00;
      byteIsCmd = 1'b0;
    end else if (step < STEP_PROG_CONF) begin
      outByte   = dstQ[8*dstRel[RIDX_W-1:0] +: 8];
      byteIsCmd = 1'b0;
    end else if (step == STEP_PROG_CONF) begin
      outByte = OP_COPY_GO;
    end
  end

  assign busyAfter = (step == STEP_RD_CONF) || (step == STEP_PROG_CONF);
  assign readAfter = (step == STEP_STATUS);

  // Pulse timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timerQ <= '0;
    else if (strobe.loadLow)  timerQ <= TW'(LOW_CLKS - 1);
    else if (strobe.loadHigh) timerQ <= TW'(HIGH_CLKS - 1);
    else if (timerQ != '0)    timerQ <= timerQ - 1'b1;
  end
  assign timerDone = (timerQ == '0);

  // Busy-wait watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                           watchQ <= '0;
    else if (strobe.clearWatch)                          watchQ <= '0;
    else if (strobe.tickWatch && watchQ != WW'(TIMEOUT)) watchQ <= watchQ + 1'b1;
  end
  assign watchExpired = (watchQ == WW'(TIMEOUT));

  // Ready/busy synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyMeta <= 1'b1;
      readyQ    <= 1'b1;
    end else begin
      readyMeta <= readyIn;
      readyQ    <= readyMeta;
    end
  end

  // Outcome register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     result <= RES_PASS;
    else if (strobe.markIllegal)   result <= RES_ILLEGAL;
    else if (strobe.markTimeout)   result <= RES_TIMEOUT;
    else if (strobe.captureStatus) result <= dataIn[0] ? RES_FAIL : RES_PASS;
  end

  AST_WATCH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tickWatch |=> watchQ <= WW'(TIMEOUT)); // R9

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accept && !strobe.nextStep) |=> $stable(step)); // R8

endmodule

// File: rtl/nand_copy_ctrl.sv
module nand_copy_ctrl
  import nand_copy_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    illegalPair,
  input  logic    readyQ,
  input  logic    timerDone,
  input  logic    watchExpired,
  input  logic    busyAfter,
  input  logic    readAfter,
  input  logic    byteIsCmd,
  output strobe_t strobe,
  output logic    reqReady,
  output logic    doneValid,
  output logic    ceN,
  output logic    cle,
  output logic    ale,
  output logic    weN,
  output logic    reN,
  output logic    dataOe
);

  state_e state, nextState;
  logic   writing;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (illegalPair) begin
            strobe.markIllegal = 1'b1;
            nextState          = S_DONE;
          end else begin
            strobe.accept  = 1'b1;
            strobe.loadLow = 1'b1;
            nextState      = S_WR_LO;
          end
        end
      end
      S_WR_LO: begin
        if (timerDone) begin
          strobe.loadHigh = 1'b1;
          nextState       = S_WR_HI;
        end
      end
      S_WR_HI: begin
        if (timerDone) begin
          if (busyAfter) begin
            strobe.clearWatch = 1'b1;
            nextState         = S_WAIT_BUSY;
          end else if (readAfter) begin
            strobe.loadLow = 1'b1;
            nextState      = S_RD_LO;
          end else begin
            strobe.nextStep = 1'b1;
            strobe.loadLow  = 1'b1;
            nextState       = S_WR_LO;
          end
        end
      end
      S_WAIT_BUSY: begin
        if (!readyQ) begin
          strobe.clearWatch = 1'b1;
          nextState         = S_WAIT_READY;
        end else if (watchExpired) begin
          strobe.markTimeout = 1'b1;
          nextState          = S_DONE;
        end else begin
          strobe.tickWatch = 1'b1;
        end
      end
      S_WAIT_READY: begin
        if (readyQ) begin
          strobe.nextStep = 1'b1;
          strobe.loadLow  = 1'b1;
          nextState       = S_WR_LO;
        end else if (watchExpired) begin
          strobe.markTimeout = 1'b1;
          nextState          = S_DONE;
        end else begin
          strobe.tickWatch = 1'b1;
        end
      end
      S_RD_LO: begin
        if (timerDone) begin
          strobe.captureStatus = 1'b1;
          strobe.loadHigh      = 1'b1;
          nextState            = S_RD_HI;
        end
      end
      S_RD_HI: begin
        if (timerDone) nextState = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign writing   = (state == S_WR_LO) || (state == S_WR_HI);
  assign ceN       = (state == S_IDLE) || (state == S_DONE);
  assign weN       = (state != S_WR_LO);
  assign reN       = (state != S_RD_LO);
  assign cle       = writing && byteIsCmd;
  assign ale       = writing && !byteIsCmd;
  assign dataOe    = writing;
  assign reqReady  = (state == S_IDLE);
  assign doneValid = (state == S_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R10

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !illegalPair) |=> (!reqReady && !ceN)); // R1

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busyAfter && $fell(cle)) |-> weN && reN); // R3

endmodule

// File: rtl/nand_copy_seq.sv
module nand_copy_seq
  import nand_copy_pkg::*;
#(
  parameter int PLANE_BIT = 6,
  parameter int DIE_BIT   = 18,
  parameter bit CHECK_DIE = 1'b1,
  parameter int LOW_CLKS  = 3,
  parameter int HIGH_CLKS = 2,
  parameter int TIMEOUT   = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [ROW_W-1:0] srcRow,
  input  logic [ROW_W-1:0] dstRow,
  output logic             doneValid,
  output logic [1:0]       doneStatus,
  output logic             flashCeN,
  output logic             flashCle,
  output logic             flashAle,
  output logic             flashWeN,
  output logic             flashReN,
  output logic [7:0]       flashDataOut,
  input  logic [7:0]       flashDataIn,
  output logic             flashDataOe,
  input  logic             flashReady
);

  strobe_t strobe;
  logic    byteIsCmd, busyAfter, readAfter, timerDone, watchExpired, readyQ, illegalPair;
  result_e result;

  nand_copy_dp #(
    .PLANE_BIT(PLANE_BIT), .DIE_BIT(DIE_BIT), .CHECK_DIE(CHECK_DIE),
    .LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS), .TIMEOUT(TIMEOUT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcRow(srcRow), .dstRow(dstRow),
    .dataIn(flashDataIn), .readyIn(flashReady), .outByte(flashDataOut),
    .byteIsCmd(byteIsCmd), .busyAfter(busyAfter), .readAfter(readAfter),
    .timerDone(timerDone), .watchExpired(watchExpired), .readyQ(readyQ),
    .illegalPair(illegalPair), .result(result)
  );

  nand_copy_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .illegalPair(illegalPair),
    .readyQ(readyQ), .timerDone(timerDone), .watchExpired(watchExpired),
    .busyAfter(busyAfter), .readAfter(readAfter), .byteIsCmd(byteIsCmd),
    .strobe(strobe), .reqReady(reqReady), .doneValid(doneValid), .ceN(flashCeN),
    .cle(flashCle), .ale(flashAle), .weN(flashWeN), .reN(flashReN), .dataOe(flashDataOe)
  );

  assign doneStatus = result;

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && illegalPair) |=> (doneValid && doneStatus == RES_ILLEGAL && flashCeN)); // R6

  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |=> (flashWeN || ($stable(flashDataOut) && $stable(flashCle)))); // R8

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == RES_TIMEOUT) |-> flashCeN && flashWeN); // R9

endmodule

// File: tb/test_nand_copy_seq.sv
module test_nand_copy_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LOW        = 2;
  localparam int HIGH       = 2;
  localparam int TMO        = 40;
  localparam int BUSY_LEN   = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] srcRow = '0, dstRow = '0;
  logic        doneValid;
  logic [1:0]  doneStatus;
  logic        flashCeN, flashCle, flashAle, flashWeN, flashReN, flashDataOe;
  logic [7:0]  flashDataOut, flashDataIn;
  logic        flashReady;

  logic [7:0]  statusByte = 8'h00;
  bit          stuck = 1'b0, noBusy = 1'b0, busySeen = 1'b0;
  int          checks = 0, errors = 0, doneCnt = 0;
  logic [9:0]  expWr[$];
  int          expDone[$];
  longint      tFall = 0;
  bit          prevDone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_copy_seq #(.LOW_CLKS(LOW), .HIGH_CLKS(HIGH), .TIMEOUT(TMO)) i_nand_copy_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .srcRow(srcRow), .dstRow(dstRow), .doneValid(doneValid), .doneStatus(doneStatus),
    .flashCeN(flashCeN), .flashCle(flashCle), .flashAle(flashAle), .flashWeN(flashWeN),
    .flashReN(flashReN), .flashDataOut(flashDataOut), .flashDataIn(flashDataIn),
    .flashDataOe(flashDataOe), .flashReady(flashReady)
  );

  assign flashDataIn = !flashReN ? statusByte : 8'hA5;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Device model: busy after 0x35 / 0x10
  initial begin
    flashReady = 1'b1;
    forever begin
      @(posedge flashWeN);
      if (flashCle && (flashDataOut == 8'h35 || flashDataOut == 8'h10) && !noBusy) begin
        repeat (2) @(posedge clk);
        #1 flashReady = 1'b0;
        busySeen = 1'b1;
        if (stuck) wait (!stuck);
        else repeat (BUSY_LEN) @(posedge clk);
        #1 flashReady = 1'b1;
      end
    end
  end

  // Write monitor (scoreboard for bus bytes)
  always @(negedge flashWeN) tFall = $time;
  always @(posedge flashWeN) begin
    logic [9:0] obs, e;
    obs = {flashCle, flashAle, flashDataOut};
    check(($time - tFall) == LOW * CLK_PERIOD, "R8", "WE low width",
          ($time - tFall) / CLK_PERIOD, LOW);
    if (expWr.size() == 0) begin
      check(1'b0, "R2/R4/R6", "unexpected bus write", obs, 0);
    end else begin
      e = expWr.pop_front();
      check(obs == e, "R2/R4", "bus write {cle,ale,byte}", obs, e);
    end
    if (flashCle && flashDataOut == 8'h85)
      check(flashReady && busySeen, "R3", "0x85 before ready cycle", {busySeen, flashReady}, 3);
  end

  // Done monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) check(!doneValid, "R10", "done pulse width", doneValid, 0);
      if (doneValid) begin
        if (expDone.size() == 0) check(1'b0, "R10", "unexpected done", doneStatus, 0);
        else begin
          int e;
          e = expDone.pop_front();
          check(int'(doneStatus) == e, "R5/R6/R7/R9", "done status", doneStatus, e);
        end
        doneCnt++;
      end
      prevDone = doneValid;
    end
  end

  task automatic pushPhase(input logic [7:0] c0, input logic [23:0] row, input logic [7:0] c1);
    expWr.push_back({2'b10, c0});
    for (int i = 0; i < 2; i++) expWr.push_back({2'b01, 8'h00});
    for (int i = 0; i < 3; i++) expWr.push_back({2'b01, row[8*i +: 8]});
    expWr.push_back({2'b10, c1});
  endtask

  // kind: 0 normal, 1 stuck busy, 2 never busy
  task automatic runCopy(input logic [23:0] s, input logic [23:0] d,
                         input logic [7:0] stat, input int kind, input string req);
    bit legal;
    int startCnt, expRes;
    legal = (s[6] == d[6]) && (s[18] == d[18]);
    if (!legal) expRes = 2;
    else if (kind != 0) expRes = 3;
    else expRes = stat[0] ? 1 : 0;
    if (legal) begin
      pushPhase(8'h00, s, 8'h35);
      if (kind == 0) begin
        pushPhase(8'h85, d, 8'h10);
        expWr.push_back({2'b10, 8'h70});
      end
    end
    expDone.push_back(expRes);
    statusByte = stat;
    stuck      = (kind == 1);
    noBusy     = (kind == 2);
    busySeen   = 1'b0;
    startCnt   = doneCnt;
    @(negedge clk);
    srcRow = s; dstRow = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (!legal) begin
      check(doneValid && flashCeN, {req, "/R6"}, "refused pair done next cycle, CE high",
            {doneValid, flashCeN}, 3);
    end else begin
      check(!reqReady && !flashCeN, "R1", "busy after accept", {reqReady, flashCeN}, 0);
    end
    while (doneCnt == startCnt) @(negedge clk);
    if (kind != 0 && legal) check(flashCeN, "R9", "CE released on timeout", flashCeN, 1);
    @(negedge clk);
    check(expWr.size() == 0, {req, "/R2/R4"}, "pending bus bytes", expWr.size(), 0);
    @(negedge clk);
    check(reqReady && flashCeN, "R1", "idle after done", {reqReady, flashCeN}, 3);
    if (stuck) begin
      stuck = 1'b0;
      repeat (5) @(negedge clk);
    end
    noBusy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && flashCeN && flashWeN && flashReN && !flashCle && !flashAle
          && !flashDataOe && !doneValid, "R1", "reset state",
          {reqReady, flashCeN, flashWeN, flashReN, flashCle, flashAle, flashDataOe, doneValid},
          8'hF0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runCopy(24'h012345, 24'h0277C0, 8'h00, 0, "R5");  // pass
    runCopy(24'h000010, 24'h0000A0, 8'h01, 0, "R5");  // fail
    runCopy(24'h050000, 24'h041122, 8'hFE, 0, "R5");  // only bit 0 counts
    runCopy(24'h000040, 24'h000000, 8'h00, 0, "R6");  // plane mismatch
    runCopy(24'h040000, 24'h000000, 8'h00, 0, "R7");  // die mismatch
    runCopy(24'h111111, 24'h222222, 8'h00, 1, "R9");  // stuck busy
    runCopy(24'h000001, 24'h000002, 8'h00, 2, "R9");  // never busy
    runCopy(24'hABCDEF, 24'hA8C4CF, 8'h00, 0, "R5");  // recovery after timeout
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule